// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Lookup

This block turns a phase address that spans one complete period into a signed sine amplitude. Only the first quarter of the wave is kept in a table. The other three quarters are rebuilt from it. The two top address bits pick the quadrant. In the second and fourth quadrants the index runs backwards, and in the second half-period the sign is flipped. The table is computed from a sine function when the design is elaborated, so no data file is needed.

A phase source, usually an accumulator, presents an address together with a valid strobe. One clock later the block returns the amplitude, in two's complement, with its own valid flag. When no valid strobe is present, the output register keeps its last value, so a downstream converter sees a steady sample between updates.

Top module: `sine_quarter_lut`

## Requirements
- R1: For every address `a` in 0..8191, the amplitude registered one cycle after a valid strobe lies within ±1 LSB of round(127·sin(2π·a/8192)).
- R2: In the first quadrant (address bits [12:11] = 00), the amplitude equals round(127·sin(π·a/4096)) exactly, except at address 2047, which returns the peak value 127.
- R3: Second-quadrant mirror: the amplitude at address 2048+k equals the amplitude at address 2047−k, for every k in 0..2047. The index bits [10:0] are inverted when address bit 11 is 1.
- R4: Half-period negation: the amplitude at address a+4096 equals the negative of the amplitude at address a, for every a in 0..4095. Address bit 12 selects the sign.
- R5: Landmark values: addresses 0 and 4096 give 0, address 2048 gives +127, address 6144 gives −127, and the output is never −128 (8'h80).
- R6: `amp_vld` is high in exactly those cycles that follow a cycle in which `phase_vld` was sampled high.
- R7: While `phase_vld` is low, `amp` holds its value, whatever `phase_addr` does.
- R8: While `rst_n` is low, `amp` is 0 and `amp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_vld | input | 1 | Phase address strobe |
| phase_addr | input | 13 | Phase address; 8192 points per period |
| amp_vld | output | 1 | Amplitude valid, one cycle after the strobe |
| amp | output | 8 | Signed two's complement amplitude, held between strobes |

## Verification
The assertions assume that `phase_vld` and `phase_addr` are driven to known values from reset onward. They also assume that the address is stable around the rising edge, because the hold and latency properties compare samples taken one edge apart. The bench changes every input on the falling edge and keeps `phase_vld` low from time zero. It reads the output on the far side of the rising edge, so every sampled input is settled and defined.

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut #(
  parameter int PW = 13,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_vld,
  input  logic [PW-1:0] phase_addr,
  output logic          amp_vld,
  output logic [AW-1:0] amp
);

  localparam int QW     = PW - 2;
  localparam int QDEPTH = 1 << QW;
  localparam int PEAK   = (1 << (AW - 1)) - 1;
  localparam real PI    = 3.14159265358979323846;

  function automatic logic [AW-2:0] quarter_val(input int i);
    real ang;
    if (i == QDEPTH - 1) return (AW-1)'(PEAK);
    ang = PI * real'(i) / real'(2 * QDEPTH);
    return (AW-1)'($rtoi(real'(PEAK) * $sin(ang) + 0.5));
  endfunction

  logic [AW-2:0] rom [QDEPTH];

  for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
    assign rom[g] = quarter_val(g);
  end

  logic [1:0]           quad;
  logic [QW-1:0]        idx;
  logic [AW-2:0]        mag;
  logic signed [AW-1:0] mag_s;
  logic signed [AW-1:0] amp_next;

  assign quad     = phase_addr[PW-1:PW-2];
  assign idx      = quad[0] ? ~phase_addr[QW-1:0] : phase_addr[QW-1:0];
  assign mag      = rom[idx];
  assign mag_s    = {1'b0, mag};
  assign amp_next = quad[1] ? -mag_s : mag_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp     <= '0;
      amp_vld <= 1'b0;
    end else begin
      amp_vld <= phase_vld;
      if (phase_vld) amp <= amp_next;
    end
  end

  p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |=> amp_vld);
  p_vld_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_vld |=> !amp_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_vld |=> $stable(amp));
  p_no_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    amp != {1'b1, {(AW-1){1'b0}}});
  p_pos_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && !phase_addr[PW-1]) |=> !amp[AW-1]);
  p_neg_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && phase_addr[PW-1]) |=> (amp[AW-1] || amp == '0));
  p_zero_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && phase_addr[PW-2:0] == '0) |=> amp == '0);
  p_peak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && phase_addr[PW-2:0] == (PW-1)'(QDEPTH)) |=>
      (amp == AW'(PEAK) || amp == AW'(-PEAK)));
  always_ff @(posedge clk) begin
    if (!rst_n) p_reset_r8: assert (amp == '0 && !amp_vld);
  end

endmodule

// File: tb/sine_quarter_lut_bench.sv
`timescale 1ns/1ps
module sine_quarter_lut_bench;

  localparam int N = 8192;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_vld = 1'b0;
  logic [12:0] phase_addr = '0;
  logic        amp_vld;
  logic [7:0]  amp;

  int checks = 0;
  int failures = 0;
  int res [N];
  bit done = 1'b0;

  always #2 clk = ~clk;

  sine_quarter_lut u_sine_quarter_lut (
    .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .phase_addr(phase_addr),
    .amp_vld(amp_vld), .amp(amp)
  );

  task automatic check(input string req, input int act, input int exp, input bit ok);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_full(input int a);
    real v;
    v = 127.0 * $sin(2.0 * PI * real'(a) / real'(N));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic apply(input int a, output int r);
    @(negedge clk);
    phase_addr = 13'(a);
    phase_vld  = 1'b1;
    @(posedge clk);
    #1;
    r = int'($signed(amp));
  endtask

  task automatic t_reset();
    #1;
    check("R8 amp in reset", int'(amp), 0, amp == 8'd0);
    check("R8 vld in reset", int'(amp_vld), 0, amp_vld == 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_sweep();
    int r;
    for (int a = 0; a < N; a++) begin
      apply(a, r);
      res[a] = r;
      check("R1 tolerance", r, ref_full(a), (r - ref_full(a)) <= 1 && (ref_full(a) - r) <= 1);
    end
    @(negedge clk); phase_vld = 1'b0;
  endtask

  task automatic t_first_quadrant();
    for (int a = 0; a < 2048; a++) begin
      int e;
      e = (a == 2047) ? 127 : $rtoi(127.0 * $sin(PI * real'(a) / 4096.0) + 0.5);
      check("R2 quadrant0 exact", res[a], e, res[a] == e);
    end
  endtask

  task automatic t_mirror();
    for (int k = 0; k < 2048; k++)
      check("R3 mirror", res[2048 + k], res[2047 - k], res[2048 + k] == res[2047 - k]);
  endtask

  task automatic t_negate();
    for (int a = 0; a < 4096; a++)
      check("R4 negation", res[a + 4096], -res[a], res[a + 4096] == -res[a]);
  endtask

  task automatic t_landmarks();
    int r;
    apply(0, r);    check("R5 zero at 0", r, 0, r == 0);
    apply(2048, r); check("R5 peak at 2048", r, 127, r == 127);
    apply(4096, r); check("R5 zero at 4096", r, 0, r == 0);
    apply(6144, r); check("R5 trough at 6144", r, -127, r == -127);
    for (int a = 0; a < N; a++)
      if (res[a] == -128) check("R5 no -128", res[a], -127, 1'b0);
    check("R5 no -128 seen", 0, 0, 1'b1);
    @(negedge clk); phase_vld = 1'b0;
  endtask

  task automatic t_valid();
    @(negedge clk); phase_vld = 1'b0;
    @(posedge clk); #1;
    check("R6 vld low after idle", int'(amp_vld), 0, amp_vld == 1'b0);
    @(negedge clk); phase_vld = 1'b1; phase_addr = 13'd100;
    #1;
    check("R6 vld not early", int'(amp_vld), 0, amp_vld == 1'b0);
    @(posedge clk); #1;
    check("R6 vld one cycle later", int'(amp_vld), 1, amp_vld == 1'b1);
    @(negedge clk); phase_vld = 1'b0;
    @(posedge clk); #1;
    check("R6 vld drops", int'(amp_vld), 0, amp_vld == 1'b0);
  endtask

  task automatic t_hold();
    int r;
    apply(1024, r);
    @(negedge clk); phase_vld = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); phase_addr = 13'(i * 1300 + 4100);
      @(posedge clk); #1;
      check("R7 hold while idle", int'($signed(amp)), res[1024], int'($signed(amp)) == res[1024]);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_first_quadrant();
    t_mirror();
    t_negate();
    t_landmarks();
    t_valid();
    t_hold();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule